// File: doc/BRIEF.md
# Prioritized Power-State Trigger Controller

This block is the decision engine of a power manager. It watches a vector of 25 trigger inputs: fault flags, wake and sleep pin conditions, on/off requests and software control bits. Each trigger has a fixed rank, and lower numbers win. The block picks the strongest trigger that is allowed in the present power state. It commits the trigger's destination state and hands a sequence number to an external sequencer with a one-cycle start strobe. The states are standby, active, MCU-only, suspend-to-RAM (retention), safe and low-power standby.

Some triggers are reentrant and may rerun their sequence without leaving the state. Some run a function and keep the state as it is. The three shutdown-class triggers preempt a running sequence. All other triggers wait until the sequencer reports that it is done. Edge-type inputs are captured and held pending. Level-type inputs are sampled each time the block arbitrates.

Top module: `pwr_trig_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (standby) and `seq_start` is low.
- R2: When several allowed triggers request at once, the one with the lowest index is served. For example, index 15 beats index 18, and index 0 beats index 2.
- R3: A trigger whose valid-state list excludes the present state is ignored. A pending edge for such a trigger is discarded and does not run in a later state.
- R4: A non-reentrant trigger whose destination is the present state produces no sequence and no state change. Examples are index 15 in active and index 4 in standby.
- R5: The reentrant error triggers rerun their sequence and keep the state. Indices 5 to 7 do this in active, and indices 8 and 9 in MCU-only. The function-only triggers 11 to 14 and 24 run without changing the state.
- R6: While a sequence is running, a non-immediate trigger starts nothing. The earliest it can start is the second clock edge after `seq_done` is sampled high.
- R7: Indices 0, 1 and 2 are immediate. While a sequence runs, each of them starts its own sequence at the next clock edge and moves the state to safe (4).
- R8: Safe (4) and low-power standby (5) are left only through reset. No trigger starts a sequence in either of them.
- R9: Edge-type inputs (default indices 13, 14, 16 and 19 to 24) are captured on a rising edge. They are held until served and start two clock edges after the rise.
- R10: Each sequence start moves the state to its destination. The encoding is 0 standby, 1 active, 2 MCU-only, 3 retention, 4 safe, 5 low-power standby. Indices 0 to 2 go to 4, index 4 goes to 0, index 10 goes to 2, indices 15 to 17 go to 1, indices 18 to 20 go to 2, indices 21 and 22 go to 3, and index 23 goes to 5. The state changes only together with `seq_start`.
- R11: `seq_start` lasts one cycle per start. `seq_id` carries the index of the trigger that was served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_in | input | 25 | Raw trigger inputs, bit index equals rank |
| seq_done | input | 1 | Sequencer reports that the running sequence has finished |
| seq_start | output | 1 | One-cycle strobe to start a sequence |
| seq_id | output | 5 | Index of the trigger whose sequence is started |
| pwr_state | output | 3 | Present power state |

## Verification
A wrong internal state shows at the ports one or two edges after the stimulus. It appears as a `pwr_state` value other than the expected one, a `seq_id` from a lower-priority trigger, or a `seq_start` that is missing or extra. A stuck or lost pending edge appears as a start that never comes or as a late start in a different state. The directed scenarios sample each response at its exact cycle. The one exception is the ignored or suppressed cases, where they watch several cycles for silence.

// File: rtl/pwr_trig_pkg.sv
package pwr_trig_pkg;
  localparam int unsigned NTRIG = 25;
  localparam int unsigned IDW   = $clog2(NTRIG);
  localparam int unsigned STW   = 3;

  typedef enum logic [STW-1:0] {
    PS_STANDBY = 3'd0,
    PS_ACTIVE  = 3'd1,
    PS_MCU     = 3'd2,
    PS_RETAIN  = 3'd3,
    PS_SAFE    = 3'd4,
    PS_LPSTBY  = 3'd5
  } pstate_e;

  typedef enum logic {PH_IDLE = 1'b0, PH_BUSY = 1'b1} phase_e;

  // Is trigger id allowed to compete in state s
  function automatic logic trig_valid(input int id, input pstate_e s);
    logic op4, am;
    op4 = (s == PS_STANDBY) || (s == PS_ACTIVE) || (s == PS_MCU) || (s == PS_RETAIN);
    am  = (s == PS_ACTIVE) || (s == PS_MCU);
    case (id)
      0, 1, 2, 4, 15, 16, 17, 18, 19: return op4;
      5, 6, 7, 10, 13, 14:            return s == PS_ACTIVE;
      8, 9:                           return s == PS_MCU;
      11, 12, 21, 22, 24:             return am;
      20:                             return am || (s == PS_RETAIN);
      23:                             return am || (s == PS_STANDBY);
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic pstate_e trig_dest(input int id, input pstate_e s);
    case (id)
      0, 1, 2:         return PS_SAFE;
      4:               return PS_STANDBY;
      10, 18, 19, 20:  return PS_MCU;
      15, 16, 17:      return PS_ACTIVE;
      21, 22:          return PS_RETAIN;
      23:              return PS_LPSTBY;
      default:         return s;
    endcase
  endfunction

  function automatic logic trig_reent(input int id);
    return (id >= 5 && id <= 9) || id == 11 || id == 12;
  endfunction

  // function-only triggers: no state change, always run
  function automatic logic trig_keeps(input int id);
    return (id >= 11 && id <= 14) || id == 24;
  endfunction

  function automatic logic trig_imm(input int id);
    return id <= 2;
  endfunction
endpackage

// File: rtl/ptc_edge_pend.sv
module ptc_edge_pend #(
  parameter int unsigned N = 25,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q, pend_q, pend_d;
      always_comb pend_d = (pend_q & ~clr[i]) | (trig[i] & ~prev_q);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= trig[i];
          pend_q <= pend_d;
        end
      end
      assign req[i] = pend_q;
    end else begin : g_level
      assign req[i] = trig[i];
    end
  end
endmodule

// File: rtl/ptc_arbiter.sv
module ptc_arbiter
  import pwr_trig_pkg::*;
#(
  parameter int unsigned N = 25,
  parameter int unsigned W = 5
) (
  input  pstate_e      cur,
  input  logic [N-1:0] req,
  output logic [N-1:0] allowed,
  output logic         win_vld,
  output logic [W-1:0] win_id
);
  for (genvar i = 0; i < N; i++) begin : g_allow
    assign allowed[i] = trig_valid(i, cur);
  end

  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && allowed[i]) begin
        win_vld = 1'b1;
        win_id  = W'(i);
      end
    end
  end
endmodule

// File: rtl/pwr_trig_ctrl.sv
module pwr_trig_ctrl
  import pwr_trig_pkg::*;
#(
  parameter int unsigned NUM_TRIG = NTRIG,
  parameter logic [NUM_TRIG-1:0] EDGE_MASK = 25'h1F96000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_TRIG-1:0]          trig_in,
  input  logic                         seq_done,
  output logic                         seq_start,
  output logic [$clog2(NUM_TRIG)-1:0]  seq_id,
  output logic [STW-1:0]               pwr_state
);
  localparam int unsigned W = $clog2(NUM_TRIG);

  pstate_e state_q, state_d, win_dest;
  phase_e  phase_q, phase_d;
  logic    start_q, start_d;
  logic [W-1:0] id_q, id_d, win_id;
  logic [NUM_TRIG-1:0] req, allowed, clr;
  logic win_vld, win_supp, win_imm, seq_busy;

  ptc_edge_pend #(.N(NUM_TRIG), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig(trig_in), .clr(clr), .req(req)
  );

  ptc_arbiter #(.N(NUM_TRIG), .W(W)) u_arb (
    .cur(state_q), .req(req), .allowed(allowed),
    .win_vld(win_vld), .win_id(win_id)
  );

  always_comb begin
    win_dest = trig_dest(int'(win_id), state_q);
    win_imm  = trig_imm(int'(win_id));
    win_supp = !trig_reent(int'(win_id)) && !trig_keeps(int'(win_id))
               && (win_dest == state_q);
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    start_d = 1'b0;
    id_d    = id_q;
    clr     = '0;
    if (phase_q == PH_IDLE) begin
      clr = ~allowed;                // drop edges not valid here
      if (win_vld) begin
        clr[win_id] = 1'b1;
        if (!win_supp) begin
          start_d = 1'b1;
          id_d    = win_id;
          state_d = win_dest;
          phase_d = PH_BUSY;
        end
      end
    end else begin
      if (win_vld && win_imm) begin  // preempt running sequence
        clr[win_id] = 1'b1;
        start_d = 1'b1;
        id_d    = win_id;
        state_d = win_dest;
      end else if (seq_done) begin
        phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_STANDBY;
      phase_q <= PH_IDLE;
      start_q <= 1'b0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      start_q <= start_d;
      if (start_d) id_q <= id_d;
    end
  end

  assign seq_busy  = (phase_q == PH_BUSY);
  assign seq_start = start_q;
  assign seq_id    = id_q;
  assign pwr_state = state_q;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int unsigned W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         seq_start,
  input logic [W-1:0] seq_id,
  input logic [2:0]   pwr_state,
  input logic         busy
);
  assert_state_moves_with_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_state) |-> seq_start);

  assert_imm_goes_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && seq_id <= 2) |-> pwr_state == 3'd4);

  assert_busy_only_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!seq_start || seq_id <= 2));

  assert_safe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd4) |=> (pwr_state == 3'd4 && !seq_start));

  assert_lpstby_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd5) |=> (pwr_state == 3'd5 && !seq_start));

  assert_id_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (seq_id != 3 && seq_id < 25));
endmodule

bind pwr_trig_ctrl ptc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_id(seq_id),
  .pwr_state(pwr_state), .busy(seq_busy)
);

// File: tb/sim_pwr_trig_ctrl.sv
module sim_pwr_trig_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [24:0] trig;
  logic done;
  logic start;
  logic [4:0] id;
  logic [2:0] st;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pwr_trig_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .seq_done(done),
    .seq_start(start), .seq_id(id), .pwr_state(st)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig = '0; done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_seq();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string req, input int n, input int exp_st);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, "start", start, 0);
    end
    chk(req, "state", st, exp_st);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "state", st, 0);
    chk("R1", "start", start, 0);
  endtask

  task automatic t_priority_and_same_state();
    trig[4] = 1'b1;                  // OFF in standby: suppressed R4
    expect_quiet("R4", 3, 0);
    trig[4] = 1'b0;
    trig[15] = 1'b1; trig[18] = 1'b1;
    @(negedge clk);
    chk("R2", "start", start, 1);
    chk("R2", "id", id, 15);
    chk("R10", "state", st, 1);
    trig = '0;
    @(negedge clk);
    chk("R11", "start", start, 0);
    finish_seq();
    trig[15] = 1'b1;                 // ON while active
    expect_quiet("R4", 3, 1);
    trig = '0;
  endtask

  task automatic t_reentrant();
    trig[8] = 1'b1;                  // MCU-only error in active: invalid R3
    expect_quiet("R3", 3, 1);
    trig[8] = 1'b0;
    trig[5] = 1'b1;
    @(negedge clk);
    chk("R5", "start", start, 1);
    chk("R5", "id", id, 5);
    chk("R5", "state", st, 1);
    trig = '0;
    finish_seq();
  endtask

  task automatic t_wait_for_done();
    trig[10] = 1'b1;
    @(negedge clk);
    chk("R10", "id", id, 10);
    chk("R10", "state", st, 2);
    trig[10] = 1'b0; trig[21] = 1'b1;
    @(negedge clk);
    trig[21] = 1'b0;
    chk("R6", "start", start, 0);
    expect_quiet("R6", 2, 2);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R6", "start", start, 0);
    @(negedge clk);
    chk("R6", "start", start, 1);
    chk("R6", "id", id, 21);
    chk("R10", "state", st, 3);
    finish_seq();
  endtask

  task automatic t_preempt_and_safe();
    trig[15] = 1'b1;
    @(negedge clk);
    chk("R10", "id", id, 15);
    chk("R10", "state", st, 1);
    trig[15] = 1'b0; trig[1] = 1'b1;
    @(negedge clk);
    chk("R7", "start", start, 1);
    chk("R7", "id", id, 1);
    chk("R7", "state", st, 4);
    trig[1] = 1'b0; trig[15] = 1'b1;
    finish_seq();
    expect_quiet("R8", 3, 4);
  endtask

  task automatic t_edges();
    do_reset();
    trig[21] = 1'b1;                 // edge invalid in standby
    @(negedge clk);
    trig[21] = 1'b0;
    expect_quiet("R3", 2, 0);
    trig[15] = 1'b1;
    @(negedge clk);
    chk("R10", "id", id, 15);
    trig[15] = 1'b0;
    finish_seq();
    expect_quiet("R3", 3, 1);        // discarded edge never runs
    trig[13] = 1'b1;
    @(negedge clk);
    trig[13] = 1'b0;
    chk("R9", "start", start, 0);
    @(negedge clk);
    chk("R9", "start", start, 1);
    chk("R9", "id", id, 13);
    chk("R5", "state", st, 1);
    finish_seq();
    trig[2] = 1'b1; trig[0] = 1'b1;
    @(negedge clk);
    chk("R2", "id", id, 0);
    chk("R10", "state", st, 4);
    trig = '0;
  endtask

  task automatic t_lpstby();
    do_reset();
    trig[23] = 1'b1;
    @(negedge clk);
    trig[23] = 1'b0;
    @(negedge clk);
    chk("R9", "id", id, 23);
    chk("R10", "state", st, 5);
    finish_seq();
    trig[15] = 1'b1;
    expect_quiet("R8", 3, 5);
    trig = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_priority_and_same_state();
    t_reentrant();
    t_wait_for_done();
    t_preempt_and_safe();
    t_edges();
    t_lpstby();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule